// File: doc/BRIEF.md
# Serial Debug Link State Monitor

This block sits on the target side of a two-wire synchronous debug link: a clock supplied by the host and one data line that both ends can drive. It samples the data line on every rising clock edge and follows the link through its phases. These phases are: unsynchronised after power-up, line reset, idle, header reception, response, loss of synchronisation and lockout. The block decides when the target may drive the line. It reports each correctly formed request header to the logic that builds the response.

A line reset is a long run of high samples. It returns the link to a known state from any phase. After a line reset, the first request the target accepts must be a read of the identification register. Malformed headers are counted. A header whose stop bit is wrong makes the target release the line and wait for the host to idle low. A second bad header in a row locks the link until the host sends another line reset. The acknowledge and the data payload are produced elsewhere. This block only opens and closes the drive windows for them, with a one-cycle turnaround on each change of driver.

Top module: `sw_link_monitor`

## Requirements
- R1: Fifty consecutive high samples of `dio_i`, seen from any phase, start a line reset. The line reset clears the lockout and the bad-header count. The first low sample after it puts the link in idle.
- R2: The high-run count restarts on every low sample and saturates, so it never wraps. Forty-nine highs followed by a low give no line reset. A high run of any length of fifty or more gives exactly one line reset, and the link stays in the reset phase until a low sample.
- R3: A header is 8 bits, sent least significant bit first, in this order:
  - start (1)
  - AP select
  - read flag
  - address bit 0
  - address bit 1
  - parity, equal to the XOR of the four preceding bits
  - stop (0)
  - park (not checked)

  A correct header makes `hdr_valid_o` high for exactly the one cycle after the park sample. In that same cycle `hdr_ap_o`, `hdr_rnw_o` and `hdr_addr_o` = {address bit 1, address bit 0} show the header. These fields are held until the next accepted header.
- R4: A header with a parity mismatch is a bad header. It gives no `hdr_valid_o`, leaves `oe_o` low, and the link then waits as in R5.
- R5: A header whose stop bit is 1 means synchronisation is lost. `oe_o` stays low, and high samples are ignored until at least one low sample has been seen. After that, a high sample is taken as a start bit.
- R6: After a line reset, the first header that is accepted must be an identification read: AP select 0, read flag 1, address 00. Any other well-formed header in that position is a bad header.
- R7: Two bad headers in a row set `locked_o` to 1 and hold `oe_o` at 0. While locked, every header is ignored until a line reset (R1).
- R8: An accepted header clears the consecutive bad-header count. The sequence bad, good, bad does not lock the link.
- R9: For a read header, the drive window runs as follows:
  - `oe_o` is 0 in the cycle after the park sample (turnaround).
  - `oe_o` is 1 for 3 acknowledge cycles, then for 33 data-plus-parity cycles.
  - `oe_o` is 0 for one turnaround cycle.
  - The link then returns to idle.
- R10: For a write header, the drive window runs as follows:
  - `oe_o` is 0 for the turnaround cycle.
  - `oe_o` is 1 for the 3 acknowledge cycles.
  - `oe_o` is 0 for one turnaround cycle.
  - The next 33 host-driven cycles are never taken as a header.
  - The link then returns to idle.
- R11: After `rst_ni` is released, the link is unsynchronised. `oe_o`, `hdr_valid_o` and `locked_o` are 0, and headers are ignored until a line reset.
- R12: In idle, low samples keep the link idle and a high sample is a start bit. A header may start in the first cycle after a transfer ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host-supplied link clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dio_i | input | 1 | Sampled value of the bidirectional data line |
| oe_o | output | 1 | Target output enable for the data line |
| hdr_valid_o | output | 1 | One-cycle pulse when a header is accepted |
| hdr_ap_o | output | 1 | AP-select bit of the last accepted header |
| hdr_rnw_o | output | 1 | Read flag of the last accepted header |
| hdr_addr_o | output | 2 | Address bits {bit 1, bit 0} of the last accepted header |
| locked_o | output | 1 | High while the link is locked out |

## Verification
A wrong phase in this block shows up first at `oe_o`. If the drive window is misplaced by one cycle, the target drives during a turnaround; the bench sees this in the cycle after the park sample, or at the end of the acknowledge or data window. A wrong bad-header count or identification flag shows up one header later: `locked_o` rises after the second bad header, or `hdr_valid_o` is missing or extra in the cycle after the park sample. A faulty high-run counter shows up as a lockout that is never cleared, or one that is cleared by a run one sample too short. The bench compares every output with a behavioural model on every cycle, so each of these faults is caught at the first cycle in which it differs.

// File: rtl/swlm_pkg.sv
package swlm_pkg;

  typedef enum logic [3:0] {
    S_UNSYNC,
    S_LRST,
    S_IDLE,
    S_HDR,
    S_TRN1,
    S_ACK,
    S_RDATA,
    S_TRN2,
    S_WDATA,
    S_LOST,
    S_LOCK
  } link_st_e;

  typedef struct packed {
    logic       ap;
    logic       rnw;
    logic [1:0] addr;
    logic       par;
    logic       stop;
  } hdr_t;

  localparam int unsigned HDR_BITS = 8;

endpackage

// File: rtl/swlm_line_reset.sv
module swlm_line_reset #(
  parameter int unsigned RST_LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic line_rst_o
);

  localparam int unsigned CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!d_i) begin
      run_q <= '0;
    end else if (run_q != CW'(RST_LEN)) begin
      run_q <= run_q + 1'b1;
    end
  end

  // fires on the RST_LEN-th consecutive high sample only
  assign line_rst_o = d_i && (run_q == CW'(RST_LEN - 1));

  a_r2_run_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(RST_LEN));

  a_r2_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_rst_o |=> !line_rst_o);

endmodule

// File: rtl/swlm_hdr_rx.sv
module swlm_hdr_rx
  import swlm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic start_i,
  input  logic cap_i,
  output logic done_o,
  output logic good_o,
  output hdr_t hdr_o
);

  localparam int unsigned IW    = $clog2(HDR_BITS);
  localparam int unsigned BODY  = HDR_BITS - 2;

  logic [IW-1:0]   idx_q;
  logic [BODY-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sreg_q <= '0;
    end else if (start_i) begin
      idx_q  <= IW'(1);
    end else if (cap_i && !done_o) begin
      idx_q  <= idx_q + 1'b1;
      sreg_q <= {d_i, sreg_q[BODY-1:1]};
    end
  end

  // current sample is the park bit
  assign done_o = cap_i && (idx_q == IW'(HDR_BITS - 1));

  assign hdr_o.ap   = sreg_q[0];
  assign hdr_o.rnw  = sreg_q[1];
  assign hdr_o.addr = {sreg_q[3], sreg_q[2]};
  assign hdr_o.par  = sreg_q[4];
  assign hdr_o.stop = sreg_q[5];

  assign good_o = !hdr_o.stop && (hdr_o.par == ^sreg_q[3:0]);

  a_r3_idx_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> idx_q != '0);

endmodule

// File: rtl/swlm_fsm.sv
module swlm_fsm
  import swlm_pkg::*;
#(
  parameter int unsigned BAD_LIMIT = 2,
  parameter int unsigned ACK_W     = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       d_i,
  input  logic       line_rst_i,
  input  logic       hdr_done_i,
  input  logic       hdr_good_i,
  input  hdr_t       hdr_i,
  output link_st_e   state_o,
  output logic       hdr_start_o,
  output logic       hdr_cap_o,
  output logic       hdr_valid_o,
  output logic       hdr_ap_o,
  output logic       hdr_rnw_o,
  output logic [1:0] hdr_addr_o,
  output logic       oe_o,
  output logic       locked_o
);

  localparam int unsigned MAXW = (DATA_W > ACK_W) ? DATA_W : ACK_W;
  localparam int unsigned PW   = $clog2(MAXW + 1);
  localparam int unsigned BW   = $clog2(BAD_LIMIT + 1);

  link_st_e    state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bad_q, bad_d;
  logic        need_id_q, need_id_d;
  logic        accept, id_ok;

  assign id_ok  = !need_id_q || (!hdr_i.ap && hdr_i.rnw && (hdr_i.addr == 2'b00));
  assign accept = hdr_done_i && hdr_good_i && id_ok;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bad_d     = bad_q;
    need_id_d = need_id_q;
    if (line_rst_i) begin
      state_d   = S_LRST;
      bad_d     = '0;
      need_id_d = 1'b1;
    end else begin
      unique case (state_q)
        S_UNSYNC, S_LOCK: ;
        S_LRST, S_LOST: if (!d_i) state_d = S_IDLE;
        S_IDLE:         if (d_i)  state_d = S_HDR;
        S_HDR: begin
          if (accept) begin
            state_d   = S_TRN1;
            bad_d     = '0;
            need_id_d = 1'b0;
          end else if (hdr_done_i) begin
            if (bad_q >= BW'(BAD_LIMIT - 1)) begin
              state_d = S_LOCK;
              bad_d   = BW'(BAD_LIMIT);
            end else begin
              state_d = S_LOST;
              bad_d   = bad_q + 1'b1;
            end
          end
        end
        S_TRN1: begin
          state_d = S_ACK;
          cnt_d   = '0;
        end
        S_ACK: begin
          if (cnt_q == PW'(ACK_W - 1)) begin
            state_d = hdr_rnw_o ? S_RDATA : S_TRN2;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_RDATA: begin
          if (cnt_q == PW'(DATA_W)) state_d = S_TRN2;
          else                      cnt_d   = cnt_q + 1'b1;
        end
        S_TRN2: begin
          state_d = hdr_rnw_o ? S_IDLE : S_WDATA;
          cnt_d   = '0;
        end
        S_WDATA: begin
          if (cnt_q == PW'(DATA_W)) state_d = S_IDLE;
          else                      cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = S_UNSYNC;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_UNSYNC;
      cnt_q       <= '0;
      bad_q       <= '0;
      need_id_q   <= 1'b1;
      hdr_valid_o <= 1'b0;
      hdr_ap_o    <= 1'b0;
      hdr_rnw_o   <= 1'b0;
      hdr_addr_o  <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      bad_q       <= bad_d;
      need_id_q   <= need_id_d;
      hdr_valid_o <= accept && !line_rst_i;
      if (accept && !line_rst_i) begin
        hdr_ap_o   <= hdr_i.ap;
        hdr_rnw_o  <= hdr_i.rnw;
        hdr_addr_o <= hdr_i.addr;
      end
    end
  end

  assign state_o     = state_q;
  assign hdr_start_o = (state_q == S_IDLE) && d_i && !line_rst_i;
  assign hdr_cap_o   = (state_q == S_HDR);
  assign oe_o        = (state_q == S_ACK) || (state_q == S_RDATA);
  assign locked_o    = (state_q == S_LOCK);

  a_r7_lock_after_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK && $past(state_q) != S_LOCK) |-> $past(bad_q) == BW'(BAD_LIMIT - 1));

  a_r8_good_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> bad_q == '0);

  a_r6_id_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && $past(need_id_q)) |-> (!hdr_ap_o && hdr_rnw_o && hdr_addr_o == 2'b00));

endmodule

// File: rtl/sw_link_monitor.sv
module sw_link_monitor
  import swlm_pkg::*;
#(
  parameter int unsigned RST_LEN   = 50,
  parameter int unsigned BAD_LIMIT = 2,
  parameter int unsigned ACK_W     = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dio_i,
  output logic       oe_o,
  output logic       hdr_valid_o,
  output logic       hdr_ap_o,
  output logic       hdr_rnw_o,
  output logic [1:0] hdr_addr_o,
  output logic       locked_o
);

  logic     line_rst, hdr_start, hdr_cap, hdr_done, hdr_good;
  hdr_t     hdr;
  link_st_e state;

  swlm_line_reset #(.RST_LEN(RST_LEN)) u_line_reset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (dio_i),
    .line_rst_o (line_rst)
  );

  swlm_hdr_rx u_hdr_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (dio_i),
    .start_i (hdr_start),
    .cap_i   (hdr_cap),
    .done_o  (hdr_done),
    .good_o  (hdr_good),
    .hdr_o   (hdr)
  );

  swlm_fsm #(
    .BAD_LIMIT (BAD_LIMIT),
    .ACK_W     (ACK_W),
    .DATA_W    (DATA_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .d_i         (dio_i),
    .line_rst_i  (line_rst),
    .hdr_done_i  (hdr_done),
    .hdr_good_i  (hdr_good),
    .hdr_i       (hdr),
    .state_o     (state),
    .hdr_start_o (hdr_start),
    .hdr_cap_o   (hdr_cap),
    .hdr_valid_o (hdr_valid_o),
    .hdr_ap_o    (hdr_ap_o),
    .hdr_rnw_o   (hdr_rnw_o),
    .hdr_addr_o  (hdr_addr_o),
    .oe_o        (oe_o),
    .locked_o    (locked_o)
  );

  a_r5_release_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_done && !hdr_good && !line_rst) |=> (!oe_o && (state == S_LOST || state == S_LOCK)));

  a_r9_turnaround_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(state) == S_TRN1);

  a_r3_valid_from_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> $past(state) == S_HDR);

  a_r7_locked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (!oe_o && !hdr_valid_o));

  a_r1_reset_from_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_LRST && $past(state) != S_LRST) |-> $past(dio_i));

endmodule

// File: tb/sw_link_monitor_bench.sv
module sw_link_monitor_bench;

  logic       clk_i = 1'b0;
  logic       rst_n = 1'b0;
  logic       din   = 1'b0;
  logic       oe, valid, ap, rnw, locked;
  logic [1:0] addr;

  int n_chk = 0, n_err = 0, valid_seen = 0;
  string cur_tag = "R11";
  bit done_flag = 0;

  always #5 clk_i = ~clk_i;

  sw_link_monitor u_sw_link_monitor (
    .clk_i(clk_i), .rst_ni(rst_n), .dio_i(din), .oe_o(oe), .hdr_valid_o(valid),
    .hdr_ap_o(ap), .hdr_rnw_o(rnw), .hdr_addr_o(addr), .locked_o(locked)
  );

  // behavioural model
  localparam int M_UNS = 0, M_LRST = 1, M_IDLE = 2, M_HDR = 3, M_RESP = 4, M_LOST = 5, M_LOCK = 6;
  int m_ph = M_UNS, m_run = 0, m_bad = 0, m_k = 0;
  bit m_need = 1, m_rnw = 0, e_valid = 0, e_ap = 0, e_rnw = 0;
  bit [1:0] e_addr = 0;
  bit q[$];

  always @(posedge clk_i) begin
    if (!rst_n) begin
      m_ph = M_UNS; m_run = 0; m_bad = 0; m_need = 1; e_valid = 0;
    end else begin
      bit fire, good, idok;
      fire = 0;
      e_valid = 0;
      if (din) begin
        if (m_run < 50) begin m_run++; fire = (m_run == 50); end
      end else m_run = 0;
      if (fire) begin
        m_ph = M_LRST; m_bad = 0; m_need = 1;
      end else begin
        case (m_ph)
          M_LRST, M_LOST: if (!din) m_ph = M_IDLE;
          M_IDLE: if (din) begin q = {}; q.push_back(1'b1); m_ph = M_HDR; end
          M_HDR: begin
            q.push_back(din);
            if (q.size() == 8) begin
              good = (q[6] == 0) && (q[5] == (q[1] ^ q[2] ^ q[3] ^ q[4]));
              idok = !m_need || (q[1] == 0 && q[2] == 1 && q[3] == 0 && q[4] == 0);
              if (good && idok) begin
                e_valid = 1; e_ap = q[1]; e_rnw = q[2]; e_addr = {q[4], q[3]};
                m_rnw = q[2]; m_bad = 0; m_need = 0; m_ph = M_RESP; m_k = 0;
              end else begin
                m_bad++;
                m_ph = (m_bad >= 2) ? M_LOCK : M_LOST;
              end
            end
          end
          M_RESP: if (m_k == 37) m_ph = M_IDLE; else m_k++;
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_oe();
    if (m_ph != M_RESP) return 0;
    if (m_k >= 1 && m_k <= 3) return 1;
    return m_rnw && m_k >= 4 && m_k <= 36;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_n && !done_flag) begin
      if (valid) valid_seen++;
      chk({cur_tag, " oe"}, oe, exp_oe());
      chk({cur_tag, " locked"}, locked, m_ph == M_LOCK);
      chk({cur_tag, " valid"}, valid, e_valid);
      if (e_valid) chk({cur_tag, " fields"}, {ap, rnw, addr}, {e_ap, e_rnw, e_addr});
    end
  end

  task automatic drive(bit b);
    @(negedge clk_i);
    #1 din = b;
  endtask

  task automatic run(bit b, int n);
    for (int i = 0; i < n; i++) drive(b);
  endtask

  task automatic hdr(bit a_p, bit r, bit [1:0] a, bit bad_par, bit bad_stop);
    bit p;
    p = a_p ^ r ^ a[0] ^ a[1] ^ bad_par;
    drive(1); drive(a_p); drive(r); drive(a[0]); drive(a[1]);
    drive(p); drive(bad_stop); drive(1);
  endtask

  int oe_cnt;
  task automatic tail();
    oe_cnt = 0;
    for (int i = 0; i < 38; i++) begin
      @(negedge clk_i);
      if (oe) oe_cnt++;
      #1 din = (i % 3 == 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk_i);
    rst_n = 1;
    #1;
    cur_tag = "R11";
    chk("R11 reset oe", oe, 0);
    chk("R11 reset locked", locked, 0);
    chk("R11 reset valid", valid, 0);
    run(0, 3); hdr(0, 1, 2'b00, 0, 0); tail();
    chk("R11 header ignored before line reset", valid_seen, 0);

    cur_tag = "R1";
    run(1, 55); run(0, 2);
    hdr(0, 1, 2'b00, 0, 0); tail();
    chk("R1 id read accepted after line reset", valid_seen, 1);
    chk("R9 read drive cycles", oe_cnt, 36);

    cur_tag = "R10";
    hdr(1, 0, 2'b10, 0, 0); tail();
    chk("R10 write accepted", valid_seen, 2);
    chk("R10 write drive cycles", oe_cnt, 3);

    cur_tag = "R12";
    run(0, 20); hdr(1, 1, 2'b11, 0, 0); tail();
    chk("R12 header after long idle", valid_seen, 3);
    chk("R9 read drive cycles again", oe_cnt, 36);

    cur_tag = "R4";
    run(0, 2); v0 = valid_seen;
    hdr(1, 0, 2'b01, 1, 0); run(0, 4);
    chk("R4 parity error not accepted", valid_seen, v0);
    chk("R4 not locked after one bad", locked, 0);
    hdr(0, 0, 2'b01, 0, 0); tail();
    chk("R8 good header after bad", valid_seen, v0 + 1);

    cur_tag = "R8";
    run(0, 1); hdr(1, 1, 2'b00, 1, 0); run(0, 1);
    chk("R8 locked after bad-good-bad", locked, 0);
    hdr(0, 1, 2'b01, 0, 0); tail();

    cur_tag = "R5";
    run(0, 1); v0 = valid_seen;
    hdr(1, 1, 2'b10, 0, 1);
    run(1, 5);
    chk("R5 highs ignored after stop error", valid_seen, v0);
    chk("R5 line released", oe, 0);
    run(0, 1); hdr(1, 0, 2'b11, 0, 0); tail();
    chk("R5 recovery after low", valid_seen, v0 + 1);

    cur_tag = "R7";
    run(0, 1); hdr(0, 0, 2'b00, 1, 0); run(0, 1); hdr(0, 0, 2'b00, 0, 1);
    run(0, 2);
    chk("R7 locked after two bad", locked, 1);
    v0 = valid_seen;
    hdr(0, 1, 2'b00, 0, 0); tail();
    chk("R7 header ignored while locked", valid_seen, v0);
    cur_tag = "R2";
    run(1, 49); run(0, 1);
    chk("R2 49 highs do not reset", locked, 1);
    run(1, 50); run(0, 1);
    chk("R1 50 highs clear lockout", locked, 0);

    cur_tag = "R6";
    hdr(1, 0, 2'b01, 0, 0); run(0, 1);
    chk("R6 non-id first header rejected", valid_seen, v0);
    hdr(0, 0, 2'b00, 0, 0); run(0, 1);
    chk("R6 second non-id locks", locked, 1);
    run(1, 60); run(0, 1);
    hdr(0, 1, 2'b00, 0, 0); tail();
    chk("R6 id read accepted", valid_seen, v0 + 1);
    hdr(1, 0, 2'b01, 0, 0); tail();
    chk("R6 other header accepted after id", valid_seen, v0 + 2);

    cur_tag = "R2";
    run(1, 200); run(0, 2);
    chk("R2 long high run not locked", locked, 0);
    hdr(0, 1, 2'b00, 0, 0); tail();
    chk("R2 single reset then id accepted", valid_seen, v0 + 3);
    run(0, 3);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule